// File: doc/BRIEF.md
# Two-Channel Hybrid Filter Bank Synthesis Stage

This block rebuilds one full-rate digital stream from two half-rate sub-converter streams. One stream holds the lowpass subband and the other holds the highpass subband. Each stream is upsampled by two with zero insertion: the sample goes in the data slot and a zero goes in the following slot. Each upsampled stream then passes through its own recursive synthesis filter, whose coefficients can be reloaded at run time. The two filter outputs are added, and the sum leaves the block as one sample per clock.

A calibration bypass sends the unfiltered sub-converter samples to the output, interleaved, so that the analog subband filters can be characterised. Coefficients are first written into a shadow set. They move into the working set only when a commit is issued while the filter memory is held clear.

Top module: `hfb_synth`

## Requirements
- R1: While reset is low, out_valid and out_data are 0. The first clock edge with reset high produces the data-slot output, with out_slot = 0. After that, out_slot alternates between 0 and 1 on every clock.
- R2: A branch input equals the channel sample only in a data slot (phase 0) where in_valid is high. In every other cycle it is zero. Sample values present in the zero slot have no effect.
- R3: Each branch computes y[n] = sum over k=0..11 of b_k*u[n-k], minus sum over k=1..11 of a_k*y[n-k]. Coefficients are signed 18-bit values with 16 fractional bits. a_0 is fixed at 1.0 and is not stored. The feedback uses the quantised branch output.
- R4: A branch output is rounded half-up from the 16 fractional bits, using floor((acc + 2^15) / 2^16), and is then saturated to the signed 16-bit range.
- R5: With bypass low, the out_data produced at a clock edge is the saturated 16-bit sum of both branch outputs for the inputs present at that edge.
- R6: Coefficient address bit 5 selects the branch (0 = lowpass, 1 = highpass). Low index 0..11 holds b_0..b_11 and low index 12..22 holds a_1..a_11. Writes to low index 23..31 have no effect.
- R7: Written coefficients take effect only after an edge where cfg_commit and flt_clear are both high. A commit without clear changes nothing. A write in the same cycle as a commit lands in the shadow set only.
- R8: An edge with flt_clear high sets every filter memory to zero. The next zero-slot output is therefore 0 when bypass is low.
- R9: With bypass high, a data-slot output equals the stuffed channel 0 input. A zero-slot output equals the stuffed channel 1 input captured at the preceding data slot.
- R10: After reset, both branches hold b_0 = 1.0 (65536) and all other coefficients 0, in both the shadow set and the working set.
- R11: After reset, out_valid is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe for both channels; high only in the data slot |
| ch0_smp | input | 16 | Lowpass subband sample, signed |
| ch1_smp | input | 16 | Highpass subband sample, signed |
| bypass | input | 1 | Calibration bypass select |
| flt_clear | input | 1 | Clears filter memories at the edge |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 6 | Coefficient address: branch bit and index |
| cfg_data | input | 18 | Coefficient value, signed, 16 fractional bits |
| cfg_commit | input | 1 | Moves the shadow set to the working set when flt_clear is high |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Reconstructed (or bypassed) sample, signed |
| out_slot | output | 1 | 0 = data slot output, 1 = zero slot output |

## Verification
The assertions assume that in_valid is raised only in the data slot. They also assume that the working coefficient set changes only through a commit issued together with a clear. The stimulus keeps to the first assumption with its own slot counter, which restarts at reset: it asks for a sample only when that counter shows the data slot. Coefficient writes, commits with and without clear, and clears are scattered through runs of live data. This shows that the gating of the working set holds under load.

// File: rtl/hfb_syn_pkg.sv
// Shared parameters and types for the two-channel synthesis stage.
// Assumes two branches only; widths here are defaults for the modules.
package hfb_syn_pkg;
    parameter int SMP_W     = 16;
    parameter int COEF_W    = 18;
    parameter int COEF_FRAC = 16;
    parameter int NUM_TAPS  = 12;
    parameter int NUM_BR    = 2;

    // Upsampler phase: data slot carries the sample, zero slot a zero
    typedef enum logic {
        SLOT_DATA = 1'b0,
        SLOT_ZERO = 1'b1
    } slot_e;
endpackage

// File: rtl/hfb_coef_bank.sv
// Shadow and working coefficient storage for one branch.
// Index 0..NTAP-1 = numerator b_k, NTAP..NC-1 = denominator a_1..a_ORD.
// Assumes wr_en is already qualified by branch select; out-of-range
// indices are dropped. Working set loads from shadow on load.
module hfb_coef_bank #(
    parameter int CW   = 18,
    parameter int FRAC = 16,
    parameter int NTAP = 12,
    parameter int ORD  = NTAP - 1,
    parameter int NC   = NTAP + ORD,
    parameter int LW   = $clog2(NC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LW-1:0]       wr_idx,
    input  logic [CW-1:0]       wr_val,
    input  logic                load,
    output logic [NTAP*CW-1:0]  b_flat,
    output logic [ORD*CW-1:0]   a_flat
);
    localparam logic [CW-1:0] UNITY = CW'(1) << FRAC;

    logic [CW-1:0] shadow [NC];
    logic [CW-1:0] active [NC];

    // Shadow set: written by the configuration port
    always_ff @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (!rst_n)
                shadow[i] <= (i == 0) ? UNITY : '0;
            else if (wr_en && (int'(wr_idx) == i))
                shadow[i] <= wr_val;
        end
    end

    // Working set: copied from shadow only on a load
    always_ff @(posedge clk) begin
        for (int i = 0; i < NC; i++) begin
            if (!rst_n)
                active[i] <= (i == 0) ? UNITY : '0;
            else if (load)
                active[i] <= shadow[i];
        end
    end

    for (genvar k = 0; k < NTAP; k++) begin : g_b
        assign b_flat[k*CW +: CW] = active[k];
    end
    for (genvar k = 0; k < ORD; k++) begin : g_a
        assign a_flat[k*CW +: CW] = active[NTAP+k];
    end
endmodule

// File: rtl/hfb_iir_df2t.sv
// Recursive filter, direct form II transposed, one input per clock.
// Output is combinational from the input and state; feedback uses the
// rounded and saturated output. Assumes the leading denominator is 1.0.
module hfb_iir_df2t #(
    parameter int DW   = 16,
    parameter int CW   = 18,
    parameter int FRAC = 16,
    parameter int NTAP = 12,
    parameter int ACCW = DW + CW + 6,
    parameter int ORD  = NTAP - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic signed [DW-1:0] u,
    input  logic [NTAP*CW-1:0]   b_flat,
    input  logic [ORD*CW-1:0]    a_flat,
    output logic signed [DW-1:0] y
);
    localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);
    localparam logic signed [ACCW-1:0] YMAX = ACCW'((1 << (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] YMIN = -ACCW'(1 << (DW - 1));

    logic signed [ACCW-1:0] st     [ORD];
    logic signed [ACCW-1:0] st_nxt [ORD];
    logic signed [ACCW-1:0] tail   [ORD];
    logic signed [ACCW-1:0] y_full;
    logic signed [ACCW-1:0] y_rnd;

    function automatic logic signed [ACCW-1:0] mul(
        input logic signed [DW-1:0] x,
        input logic [CW-1:0]        c
    );
        logic signed [ACCW-1:0] xe;
        logic signed [ACCW-1:0] ce;
        xe  = ACCW'(x);
        ce  = ACCW'(signed'(c));
        return xe * ce;
    endfunction

    // Output tap: accumulate, round half up, saturate
    always_comb begin
        y_full = mul(u, b_flat[0 +: CW]) + st[0];
        y_rnd  = (y_full + HALF) >>> FRAC;
        if (y_rnd > YMAX)
            y = DW'(YMAX);
        else if (y_rnd < YMIN)
            y = DW'(YMIN);
        else
            y = DW'(y_rnd);
    end

    for (genvar k = 0; k < ORD; k++) begin : g_tail
        if (k < ORD - 1) begin : g_mid
            assign tail[k] = st[k+1];
        end else begin : g_end
            assign tail[k] = '0;
        end
        assign st_nxt[k] = mul(u, b_flat[(k+1)*CW +: CW])
                         - mul(y, a_flat[k*CW +: CW])
                         + tail[k];
    end

    // State chain: clear on reset or clr, else advance
    always_ff @(posedge clk) begin
        for (int k = 0; k < ORD; k++) begin
            if (!rst_n || clr)
                st[k] <= '0;
            else
                st[k] <= st_nxt[k];
        end
    end
endmodule

// File: rtl/hfb_synth.sv
// Two-channel synthesis stage: zero-stuffing upsamplers, one recursive
// filter per branch, saturated sum, and a raw calibration bypass.
// Assumes in_valid is raised only when the internal phase is the data
// slot; the phase starts in the data slot after reset.
module hfb_synth
    import hfb_syn_pkg::*;
#(
    parameter int DW   = SMP_W,
    parameter int CW   = COEF_W,
    parameter int FRAC = COEF_FRAC,
    parameter int NTAP = NUM_TAPS,
    parameter int ACCW = DW + CW + 6,
    parameter int ORD  = NTAP - 1,
    parameter int NC   = NTAP + ORD,
    parameter int LW   = $clog2(NC),
    parameter int AW   = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] ch0_smp,
    input  logic [DW-1:0] ch1_smp,
    input  logic          bypass,
    input  logic          flt_clear,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_data,
    input  logic          cfg_commit,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_slot
);
    localparam int SUMW = DW + 1;
    localparam logic signed [SUMW-1:0] SMAX = SUMW'((1 << (DW - 1)) - 1);
    localparam logic signed [SUMW-1:0] SMIN = -SUMW'(1 << (DW - 1));

    slot_e                  ph;
    logic signed [DW-1:0]   u_br  [NUM_BR];
    logic signed [DW-1:0]   y_br  [NUM_BR];
    logic [NTAP*CW-1:0]     b_br  [NUM_BR];
    logic [ORD*CW-1:0]      a_br  [NUM_BR];
    logic signed [DW-1:0]   hold1;
    logic signed [SUMW-1:0] sum_w;
    logic signed [DW-1:0]   sum_sat;
    logic                   coef_load;
    logic [NUM_BR*NC*CW-1:0] act_all;

    assign coef_load = cfg_commit && flt_clear;

    // Zero stuffing: sample in the data slot, zero elsewhere
    assign u_br[0] = (ph == SLOT_DATA && in_valid) ? signed'(ch0_smp) : '0;
    assign u_br[1] = (ph == SLOT_DATA && in_valid) ? signed'(ch1_smp) : '0;

    for (genvar br = 0; br < NUM_BR; br++) begin : g_br
        logic wr_sel;
        assign wr_sel = cfg_we && (cfg_addr[AW-1] == br[0]);

        hfb_coef_bank #(
            .CW(CW), .FRAC(FRAC), .NTAP(NTAP), .ORD(ORD), .NC(NC), .LW(LW)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_sel),
            .wr_idx (cfg_addr[LW-1:0]),
            .wr_val (cfg_data),
            .load   (coef_load),
            .b_flat (b_br[br]),
            .a_flat (a_br[br])
        );

        hfb_iir_df2t #(
            .DW(DW), .CW(CW), .FRAC(FRAC), .NTAP(NTAP), .ACCW(ACCW), .ORD(ORD)
        ) u_iir (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (flt_clear),
            .u      (u_br[br]),
            .b_flat (b_br[br]),
            .a_flat (a_br[br]),
            .y      (y_br[br])
        );

        assign act_all[br*NC*CW +: NC*CW] = {a_br[br], b_br[br]};
    end

    // Branch recombination with saturation to the sample width
    always_comb begin
        sum_w = SUMW'(y_br[0]) + SUMW'(y_br[1]);
        if (sum_w > SMAX)
            sum_sat = DW'(SMAX);
        else if (sum_w < SMIN)
            sum_sat = DW'(SMIN);
        else
            sum_sat = DW'(sum_w);
    end

    // Phase, bypass hold and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= SLOT_DATA;
            hold1     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_slot  <= 1'b0;
        end else begin
            ph        <= (ph == SLOT_DATA) ? SLOT_ZERO : SLOT_DATA;
            if (ph == SLOT_DATA)
                hold1 <= u_br[1];
            out_valid <= 1'b1;
            out_slot  <= (ph == SLOT_ZERO);
            if (bypass)
                out_data <= (ph == SLOT_DATA) ? u_br[0] : hold1;
            else
                out_data <= sum_sat;
        end
    end
endmodule

// File: rtl/hfb_synth_chk.sv
// Property checker for hfb_synth, attached by bind below.
// Assumes reset is held low from time zero.
module hfb_synth_chk #(
    parameter int DW = 16,
    parameter int CW = 18,
    parameter int AW = 6,
    parameter int ACTW = 2 * 23 * 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [DW-1:0]   ch0_smp,
    input logic            bypass,
    input logic            flt_clear,
    input logic            cfg_commit,
    input logic            out_valid,
    input logic [DW-1:0]   out_data,
    input logic            out_slot,
    input logic            ph,
    input logic [ACTW-1:0] act_all
);
    // R11
    valid_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid);

    // R1
    first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rst_n, 2)) |-> !out_slot);

    // R1
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_slot != $past(out_slot)));

    // R2
    valid_in_data_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (ph == 1'b0));

    // R7
    coef_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_commit && flt_clear)) |-> $stable(act_all));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(flt_clear, 2) && !$past(bypass) && out_slot)
        |-> (out_data == '0));

    // R9
    bypass_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass) && $past(in_valid) && !out_slot)
        |-> (out_data == $past(ch0_smp)));
endmodule

bind hfb_synth hfb_synth_chk #(
    .DW(DW), .CW(CW), .AW(AW), .ACTW(NUM_BR * NC * CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .ch0_smp    (ch0_smp),
    .bypass     (bypass),
    .flt_clear  (flt_clear),
    .cfg_commit (cfg_commit),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_slot   (out_slot),
    .ph         (ph),
    .act_all    (act_all)
);

// File: tb/hfb_synth_tb.sv
// Bench for hfb_synth: behavioural reference model stepped once per
// clock and compared against the outputs after every edge.
module hfb_synth_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] ch0_smp = '0;
    logic [15:0] ch1_smp = '0;
    logic        bypass = 1'b0;
    logic        flt_clear = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [17:0] cfg_data = '0;
    logic        cfg_commit = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_slot;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state
    longint mb  [2][12];
    longint ma  [2][12];
    longint sb  [2][12];
    longint sa  [2][12];
    longint st  [2][11];
    longint hold1;
    int     mph;

    always #4 clk = ~clk;

    hfb_synth u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch0_smp(ch0_smp), .ch1_smp(ch1_smp), .bypass(bypass),
        .flt_clear(flt_clear), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit),
        .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot)
    );

    function automatic longint sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 12; k++) begin
                mb[b][k] = (k == 0) ? 65536 : 0;
                sb[b][k] = mb[b][k];
                ma[b][k] = 0;
                sa[b][k] = 0;
            end
            for (int k = 0; k < 11; k++) st[b][k] = 0;
        end
        hold1 = 0;
        mph = 0;
    endtask

    // One clock: drive at negedge, step model, check after the edge
    task automatic cyc(input bit v, input int c0, input int c1, input bit byp,
                       input bit clr, input bit we, input int addr, input int data,
                       input bit com, input string tag);
        longint u [2];
        longint y [2];
        longint ns [11];
        longint yf, ex;
        int ex_slot;
        bit vv;
        vv = v && (mph == 0);
        in_valid = vv; ch0_smp = 16'(c0); ch1_smp = 16'(c1);
        bypass = byp; flt_clear = clr; cfg_we = we;
        cfg_addr = 6'(addr); cfg_data = 18'(data); cfg_commit = com;
        u[0] = vv ? longint'(signed'(16'(c0))) : 0;
        u[1] = vv ? longint'(signed'(16'(c1))) : 0;
        for (int b = 0; b < 2; b++) begin
            yf = mb[b][0] * u[b] + st[b][0];
            y[b] = sat16((yf + 32768) >>> 16);
            for (int k = 0; k < 11; k++)
                ns[k] = mb[b][k+1] * u[b] - ma[b][k+1] * y[b] + ((k < 10) ? st[b][k+1] : 0);
            for (int k = 0; k < 11; k++) st[b][k] = clr ? 0 : ns[k];
        end
        ex = byp ? ((mph == 0) ? u[0] : hold1) : sat16(y[0] + y[1]);
        ex_slot = mph;
        if (mph == 0) hold1 = u[1];
        mph ^= 1;
        if (com && clr) begin
            mb = sb;
            ma = sa;
        end
        if (we) begin
            if ((addr & 31) < 12) sb[(addr >> 5) & 1][addr & 31] = data;
            else if ((addr & 31) < 23) sa[(addr >> 5) & 1][(addr & 31) - 11] = data;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, longint'(signed'(out_data)), ex);
        chk("R1 slot", out_slot, ex_slot);
        chk("R11 valid", out_valid, 1);
    endtask

    task automatic run(input int n, input int seed, input string tag);
        for (int i = 0; i < n; i++)
            cyc(1, ((i + seed) * 7919) % 40000 - 20000,
                ((i + seed) * 104729) % 36000 - 18000,
                0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int addr, input int data, input string tag);
        cyc(1, 1234, -4321, 0, 0, 1, addr, data, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: outputs held at zero during reset
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset valid", out_valid, 0);
            chk("R1 reset data", out_data, 0);
        end
        rst_n = 1'b1;
        // R10 and R5: default coefficients pass both channels through
        run(16, 3, "R10 R5 passthrough");
        // R4 / R5: sum saturation both ways
        cyc(1, 30000, 30000, 0, 0, 0, 0, 0, 0, "R5 sat high");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        cyc(1, -30000, -30000, 0, 0, 0, 0, 0, 0, "R5 sat low");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R2: data slot without valid, and zero-slot values ignored
        cyc(0, 9999, -9999, 0, 0, 0, 0, 0, 0, "R2 no valid");
        cyc(1, 11111, 22222, 0, 0, 0, 0, 0, 0, "R2 zero slot");
        cyc(1, 500, 700, 0, 0, 0, 0, 0, 0, "R2 data slot");
        cyc(1, 11111, 22222, 0, 0, 0, 0, 0, 0, "R2 zero slot");
        // R6: lowpass on branch 0, highpass on branch 1 into the shadow set
        wr(0, 16384, "R6"); wr(1, 32768, "R6"); wr(2, 16384, "R6");
        wr(12, -32768, "R6"); wr(13, 16384, "R6");
        wr(32, 16384, "R6"); wr(33, -32768, "R6"); wr(34, 16384, "R6");
        wr(44, 32768, "R6"); wr(45, 16384, "R6");
        // R6: out-of-range index ignored
        wr(25, 131071, "R6 ignored");
        wr(63, -131072, "R6 ignored");
        // R7: no effect without commit or with commit alone
        run(6, 11, "R7 no commit");
        cyc(1, 3000, 3000, 0, 0, 0, 0, 0, 1, "R7 commit no clear");
        run(6, 17, "R7 still old");
        // R7: commit with clear, with a same-cycle write to shadow only
        cyc(1, 3000, -3000, 0, 1, 1, 3, 9000, 1, "R7 commit");
        // R3: recursive response on both branches
        run(60, 23, "R3 iir");
        for (int i = 0; i < 20; i++)
            cyc(1, 20000, (i % 2 == 0) ? 20000 : -20000, 0, 0, 0, 0, 0, 0, "R3 step");
        // R8: clear mid-stream
        cyc(1, 8000, -8000, 0, 1, 0, 0, 0, 0, "R8 clear");
        cyc(1, 8000, -8000, 0, 0, 0, 0, 0, 0, "R8 after");
        cyc(1, 8000, -8000, 0, 1, 0, 0, 0, 0, "R8 clear");
        cyc(1, 8000, -8000, 0, 0, 0, 0, 0, 0, "R8 after");
        run(10, 41, "R8 resume");
        // R4: large gain forces branch saturation
        wr(0, 131071, "R4"); wr(1, 0, "R4"); wr(2, 0, "R4"); wr(3, 0, "R4");
        wr(12, 0, "R4"); wr(13, 0, "R4");
        wr(32, 0, "R4"); wr(33, 0, "R4"); wr(34, 0, "R4");
        wr(44, 0, "R4"); wr(45, 0, "R4");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, "R4 commit");
        cyc(1, 30000, 0, 0, 0, 0, 0, 0, 0, "R4 sat high");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, -30000, 0, 0, 0, 0, 0, 0, 0, "R4 sat low");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R4 rounding");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        cyc(1, -7, 0, 0, 0, 0, 0, 0, 0, "R4 rounding");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R9: bypass exposes raw channels, including a missing sample
        for (int i = 0; i < 12; i++)
            cyc(i != 4, 1000 * i - 5000, -700 * i + 3000, 1, 0, 0, 0, 0, 0, "R9 bypass");
        run(8, 57, "R5 return");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule